// File: doc/BRIEF.md
# Load Data Extension Unit

This block belongs to the memory stage of a 64-bit load/store pipeline. It receives the full 64-bit doubleword read from data memory, the three low bits of the effective address, and the 7-bit opcode and 3-bit funct3 field of the instruction in that stage. It works out which load variant is executing, picks the addressed byte, halfword or word lane out of the doubleword, and widens that lane to 64 bits. Signed variants fill the upper bits with the lane's top bit. Unsigned variants fill them with zeros.

The block is purely combinational, so the result is ready in the same cycle for the write-back register. It also drives the decoded zero-extend control line, which is 1 only for unsigned loads. When the instruction is not a load, the memory data passes through unchanged and the control line is 0. The write-back path ignores the value in that case.

Top module: `ldx_unit`

## Requirements
- R1: The load opcode is 7'b0000011. For any other opcode, `load_value` equals `mem_data` and `zero_ext` is 0, whatever funct3 is.
- R2: Under the load opcode, funct3 3'b010 is a signed word load. The result holds the selected 32-bit word in bits 31:0, and bit 31 of that word is copied into bits 63:32.
- R3: funct3 3'b110 is an unsigned word load. The result holds the selected word in bits 31:0, and bits 63:32 are 0.
- R4: funct3 3'b100 is an unsigned byte load. The result holds the selected byte in bits 7:0, and bits 63:8 are 0.
- R5: funct3 3'b000 is a signed byte load. The result holds the selected byte in bits 7:0, and bit 7 of that byte is copied into bits 63:8.
- R6: funct3 3'b001 is a signed halfword load and 3'b101 is an unsigned halfword load. The selected 16 bits go to bits 15:0, and bits 63:16 get bit 15 of the halfword (signed) or 0 (unsigned).
- R7: funct3 3'b011 is a full doubleword load. The result equals `mem_data` for every address value.
- R8: funct3 3'b111 under the load opcode is not a defined load. The result equals `mem_data` and `zero_ext` is 0.
- R9: `zero_ext` is 1 exactly when the opcode is the load opcode and funct3 is 3'b100, 3'b101 or 3'b110.
- R10: Lane selection is little-endian. Byte k is `mem_data[8k+7:8k]`.
  - Byte loads use `addr_lo[2:0]` as k.
  - Halfword loads use `addr_lo[2:1]` as the halfword index, and `addr_lo[0]` has no effect.
  - Word loads use `addr_lo[2]` as the word index, and `addr_lo[1:0]` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_data | input | 64 | Doubleword read from data memory |
| addr_lo | input | 3 | Low bits of the effective address |
| opcode | input | 7 | Major opcode of the instruction in the memory stage |
| funct3 | input | 3 | Load variant field |
| load_value | output | 64 | Sized and extended value for write-back |
| zero_ext | output | 1 | Decoded zero-extend control (1 for unsigned loads) |

## Verification
Each variant is driven with lanes whose top bit is 1 and lanes whose top bit is 0, for example 0x80 against 0x7F and 0x80000000 against 0x01234567. A design with swapped sign and zero extension, or with a fill bit taken from the wrong position, fails on one of these. Misaligned address bits (addr_lo[0] on a halfword, addr_lo[1:0] on a word) are set to catch a lane decoder that uses too many address bits. The highest lanes (byte 7, halfword 3, word 1) are included to catch an off-by-one lane index. Non-load opcodes and the undefined funct3 are checked for pass-through with `zero_ext` low, which catches a decoder that ignores the opcode or maps the spare code to an unsigned variant.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    localparam int XLEN     = 64;
    localparam int NBYTE    = XLEN / 8;
    localparam int AW       = $clog2(NBYTE);
    localparam int OPC_W    = 7;
    localparam int F3_W     = 3;

    localparam logic [OPC_W-1:0] OPC_LOAD = 7'b0000011;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_FULL = 2'd3
    } ld_size_e;

    typedef struct packed {
        logic     is_load;
        ld_size_e size;
        logic     zext;
    } ld_ctrl_t;

    typedef struct packed {
        logic [31:0] w;
        logic [15:0] h;
        logic [7:0]  b;
    } ld_lanes_t;

    // Widen the low 'bits' bits of raw; the upper bits get the fill bit
    // (0 when zext is set, otherwise sgn).
    function automatic logic [XLEN-1:0] widen(
        input logic [XLEN-1:0] raw,
        input int              bits,
        input logic            zext,
        input logic            sgn
    );
        logic [XLEN-1:0] out;
        for (int i = 0; i < XLEN; i++) begin
            out[i] = (i < bits) ? raw[i] : (~zext & sgn);
        end
        return out;
    endfunction

endpackage

// File: rtl/ldx_decode.sv
module ldx_decode
    import ldx_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [F3_W-1:0]  funct3,
    output ld_ctrl_t         ctrl
);
    always_comb begin
        ctrl.is_load = (opcode == OPC_LOAD);
        ctrl.size    = SZ_FULL;
        ctrl.zext    = 1'b0;
        if (ctrl.is_load) begin
            unique case (funct3)
                3'b000: ctrl.size = SZ_BYTE;
                3'b001: ctrl.size = SZ_HALF;
                3'b010: ctrl.size = SZ_WORD;
                3'b011: ctrl.size = SZ_FULL;
                3'b100: begin ctrl.size = SZ_BYTE; ctrl.zext = 1'b1; end
                3'b101: begin ctrl.size = SZ_HALF; ctrl.zext = 1'b1; end
                3'b110: begin ctrl.size = SZ_WORD; ctrl.zext = 1'b1; end
                default: ctrl.size = SZ_FULL;
            endcase
        end
    end

    // R9: unsigned control only for the three unsigned codes under a load
    always_comb begin
        a_r9_zext_codes: assert (ctrl.zext == (ctrl.is_load &&
            (funct3 == 3'b100 || funct3 == 3'b101 || funct3 == 3'b110)));
    end
endmodule

// File: rtl/ldx_lane_select.sv
module ldx_lane_select
    import ldx_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic [DW-1:0]        data,
    input  logic [$clog2(DW/8)-1:0] addr,
    output ld_lanes_t            lanes
);
    localparam int NB  = DW / 8;
    localparam int NH  = DW / 16;
    localparam int NW  = DW / 32;
    localparam int LAW = $clog2(NB);

    logic [7:0]  blane [NB];
    logic [15:0] hlane [NH];
    logic [31:0] wlane [NW];

    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign blane[k] = data[8*k +: 8];
    end
    for (genvar k = 0; k < NH; k++) begin : g_half
        assign hlane[k] = data[16*k +: 16];
    end
    for (genvar k = 0; k < NW; k++) begin : g_word
        assign wlane[k] = data[32*k +: 32];
    end

    assign lanes.b = blane[addr];
    assign lanes.h = hlane[addr[LAW-1:1]];
    assign lanes.w = wlane[addr[LAW-1:2]];
endmodule

// File: rtl/ldx_extend.sv
module ldx_extend
    import ldx_pkg::*;
(
    input  logic [XLEN-1:0] full,
    input  ld_lanes_t       lanes,
    input  ld_size_e        size,
    input  logic            zext,
    output logic [XLEN-1:0] result
);
    always_comb begin
        unique case (size)
            SZ_BYTE: result = widen({{(XLEN-8){1'b0}},  lanes.b}, 8,  zext, lanes.b[7]);
            SZ_HALF: result = widen({{(XLEN-16){1'b0}}, lanes.h}, 16, zext, lanes.h[15]);
            SZ_WORD: result = widen({{(XLEN-32){1'b0}}, lanes.w}, 32, zext, lanes.w[31]);
            default: result = full;
        endcase
    end

    always_comb begin
        // R2: signed word copies bit 31 upward
        if (size == SZ_WORD && !zext)
            a_r2_word_sign_fill: assert (result[63:32] == {32{lanes.w[31]}});
        // R3: unsigned word clears the upper half
        if (size == SZ_WORD && zext)
            a_r3_word_zero_fill: assert (result[63:32] == 32'h0 && result[31:0] == lanes.w);
        // R4: unsigned byte clears bits above the byte
        if (size == SZ_BYTE && zext)
            a_r4_byte_zero_fill: assert (result == {{(XLEN-8){1'b0}}, lanes.b});
        // R7: full load passes data through
        if (size == SZ_FULL)
            a_r7_full_pass: assert (result == full);
    end
endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
    import ldx_pkg::*;
(
    input  logic [63:0] mem_data,
    input  logic [2:0]  addr_lo,
    input  logic [6:0]  opcode,
    input  logic [2:0]  funct3,
    output logic [63:0] load_value,
    output logic        zero_ext
);
    ld_ctrl_t  ctrl;
    ld_lanes_t lanes;

    ldx_decode u_dec (
        .opcode (opcode),
        .funct3 (funct3),
        .ctrl   (ctrl)
    );

    ldx_lane_select #(.DW(XLEN)) u_lane (
        .data  (mem_data),
        .addr  (addr_lo),
        .lanes (lanes)
    );

    ldx_extend u_ext (
        .full   (mem_data),
        .lanes  (lanes),
        .size   (ctrl.size),
        .zext   (ctrl.zext),
        .result (load_value)
    );

    assign zero_ext = ctrl.zext;

    always_comb begin
        // R1: non-load opcodes pass data through with the control line low
        if (opcode != OPC_LOAD)
            a_r1_nonload_pass: assert (load_value == mem_data && !zero_ext);
        // R9: the control line never rises outside a load
        if (zero_ext)
            a_r9_zext_is_load: assert (ctrl.is_load);
    end
endmodule

// File: tb/sim_ldx_unit.sv
module sim_ldx_unit;
    logic        clk = 1'b0;
    logic [63:0] mem_data;
    logic [2:0]  addr_lo;
    logic [6:0]  opcode;
    logic [2:0]  funct3;
    logic [63:0] load_value;
    logic        zero_ext;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ldx_unit u0 (
        .mem_data   (mem_data),
        .addr_lo    (addr_lo),
        .opcode     (opcode),
        .funct3     (funct3),
        .load_value (load_value),
        .zero_ext   (zero_ext)
    );

    typedef struct packed {
        logic [6:0]  opc;
        logic [2:0]  f3;
        logic [2:0]  adr;
        logic [63:0] dat;
        logic [63:0] exp_v;
        logic        exp_z;
        logic [7:0]  req;
    } vec_t;

    localparam logic [6:0]  LD = 7'b0000011;
    localparam logic [63:0] DA = 64'hF1E2_8374_A5B6_47D8;
    localparam logic [63:0] DB = 64'h0123_4567_89AB_CDEF;
    localparam int NV = 20;

    localparam vec_t VECS [NV] = '{
        '{LD, 3'b000, 3'd0, DA, 64'hFFFF_FFFF_FFFF_FFD8, 1'b0, 8'd5},  // R5 neg byte
        '{LD, 3'b000, 3'd1, DA, 64'h0000_0000_0000_0047, 1'b0, 8'd5},  // R5 pos byte
        '{LD, 3'b100, 3'd0, DA, 64'h0000_0000_0000_00D8, 1'b1, 8'd4},  // R4
        '{LD, 3'b100, 3'd7, DA, 64'h0000_0000_0000_00F1, 1'b1, 8'd10}, // R10 top byte
        '{LD, 3'b000, 3'd7, DA, 64'hFFFF_FFFF_FFFF_FFF1, 1'b0, 8'd10}, // R10
        '{LD, 3'b001, 3'd2, DA, 64'hFFFF_FFFF_FFFF_A5B6, 1'b0, 8'd6},  // R6 signed half
        '{LD, 3'b001, 3'd0, DA, 64'h0000_0000_0000_47D8, 1'b0, 8'd6},  // R6 positive
        '{LD, 3'b101, 3'd6, DA, 64'h0000_0000_0000_F1E2, 1'b1, 8'd6},  // R6 unsigned
        '{LD, 3'b001, 3'd3, DA, 64'hFFFF_FFFF_FFFF_A5B6, 1'b0, 8'd10}, // R10 addr bit0
        '{LD, 3'b010, 3'd0, DA, 64'hFFFF_FFFF_A5B6_47D8, 1'b0, 8'd2},  // R2
        '{LD, 3'b010, 3'd4, DA, 64'hFFFF_FFFF_F1E2_8374, 1'b0, 8'd2},  // R2 upper word
        '{LD, 3'b110, 3'd4, DA, 64'h0000_0000_F1E2_8374, 1'b1, 8'd3},  // R3
        '{LD, 3'b110, 3'd0, DA, 64'h0000_0000_A5B6_47D8, 1'b1, 8'd3},  // R3
        '{LD, 3'b010, 3'd7, DA, 64'hFFFF_FFFF_F1E2_8374, 1'b0, 8'd10}, // R10 addr 1:0
        '{LD, 3'b011, 3'd0, DA, DA,                      1'b0, 8'd7},  // R7
        '{LD, 3'b011, 3'd5, DA, DA,                      1'b0, 8'd7},  // R7
        '{LD, 3'b111, 3'd2, DA, DA,                      1'b0, 8'd8},  // R8
        '{7'b0110011, 3'b110, 3'd0, DA, DA,              1'b0, 8'd1},  // R1
        '{LD, 3'b010, 3'd4, DB, 64'h0000_0000_0123_4567, 1'b0, 8'd2},  // R2 pos word
        '{LD, 3'b001, 3'd6, DB, 64'h0000_0000_0000_0123, 1'b0, 8'd6}   // R6
    };

    task automatic apply_check(input logic [6:0] o, input logic [2:0] f,
                               input logic [2:0] a, input logic [63:0] d,
                               input logic [63:0] ev, input logic ez,
                               input int rq);
        @(negedge clk);
        opcode = o; funct3 = f; addr_lo = a; mem_data = d;
        #1;
        checks++;
        if (load_value !== ev || zero_ext !== ez) begin
            errors++;
            $display("FAIL R%0d: value=%h zext=%b expected value=%h zext=%b",
                     rq, load_value, zero_ext, ev, ez);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        opcode = '0; funct3 = '0; addr_lo = '0; mem_data = '0;
        // Reset-like idle inputs: R1 pass-through of zero data
        apply_check(7'h00, 3'b000, 3'd0, 64'h0, 64'h0, 1'b0, 1);

        for (int i = 0; i < NV; i++) begin
            apply_check(VECS[i].opc, VECS[i].f3, VECS[i].adr, VECS[i].dat,
                        VECS[i].exp_v, VECS[i].exp_z, int'(VECS[i].req));
        end

        // R5 / R4 boundary: byte 0x80 and 0x7F
        apply_check(LD, 3'b000, 3'd3, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 5);
        apply_check(LD, 3'b100, 3'd3, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0080, 1'b1, 4);
        apply_check(LD, 3'b000, 3'd2, 64'h0000_0000_007F_0000, 64'h0000_0000_0000_007F, 1'b0, 5);
        // R2 / R3 boundary: word 0x80000000
        apply_check(LD, 3'b010, 3'd1, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_8000_0000, 1'b0, 2);
        apply_check(LD, 3'b110, 3'd2, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b1, 3);
        // R9: unsigned funct3 under a non-load opcode keeps the line low
        apply_check(7'b0100011, 3'b100, 3'd0, DA, DA, 1'b0, 9);
        apply_check(7'b0000010, 3'b101, 3'd0, DA, DA, 1'b0, 9);
        // R9 / R8: spare code with all-ones data
        apply_check(LD, 3'b111, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule